// File: doc/BRIEF.md
# Dual-Speed MII Transmit Framer

This block drives the transmit side of one repeater port toward an MII PHY. An upstream core hands it a frame one byte at a time with a valid/ready handshake. For each byte the core also gives a last-byte flag and a coding-error request, and it can signal a collision at any time. The framer puts the preamble and start-of-frame delimiter in front of the data, then serialises each byte. At 100 Mbit/s it sends nibbles on `txd[3:0]`. At 10 Mbit/s it sends single bits on `txd[0]`. It also drives `tx_en` and `tx_er`, and it passes receive data valid straight through as a link-status flag.

Everything runs on one system clock. The output timing comes from one of two single-cycle strobes. `phy_tick` marks an edge of the PHY transmit clock and `int_tick` marks an edge of an internal 25 MHz clock. The configuration input `use_phy_clk` chooses between them. The outputs change only on a cycle where the selected strobe is high.

Top module: `mii_tx_framer`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `tx_en`, `tx_er`, `txd` and `in_ready` are all 0. This holds even if reset arrives in the middle of a frame.
- R2: The framer advances only on cycles where the selected strobe is high. The strobe is `phy_tick` when `use_phy_clk`=1 and `int_tick` when `use_phy_clk`=0. The other strobe has no effect.
- R3: In 100 Mbit/s mode, `tx_en` rises on the tick that sends the first preamble nibble. Fifteen nibbles of 0x5 go out, then one 0xD. Data starts on the 17th tick, with each byte sent low nibble first.
- R4: In 10 Mbit/s mode, `txd[0]` carries 62 alternating bits starting with 1, then two 1 bits. After that each byte is sent least significant bit first, and `txd[3:1]` stays 0.
- R5: On the tick after the last symbol of the byte flagged by `in_last`, `tx_en` goes to 0 and `txd` goes to 0. A new frame starts no earlier than the following tick.
- R6: `in_ready` is high only in a strobe cycle where the framer needs a byte: the tick after the final preamble symbol, or the tick after the last symbol of a byte that was not flagged last. Each byte in the frame is taken exactly once, on `in_valid` and `in_ready`.
- R7: In 100 Mbit/s mode, `tx_er` rises on the symbol that starts a byte accepted with `in_err_req`=1. It then stays high until the end of the frame.
- R8: A tick with `in_collision`=1 forces `tx_er` to 0 and cancels the pending error request for the rest of the frame. A collision wins over an error request accepted on the same tick.
- R9: In 10 Mbit/s mode `tx_er` is never asserted.
- R10: The mode is taken from `speed_100` on the tick that starts a frame (1 = 100 Mbit/s, 0 = 10 Mbit/s) and is held until the frame ends.
- R11: If `in_valid` is low on a tick where a byte is needed, the frame ends on that tick: `tx_en` and `txd` go to 0.
- R12: `link_ok` equals `rx_dv` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_100 | input | 1 | Speed select: 1 = 100 Mbit/s nibbles, 0 = 10 Mbit/s serial |
| use_phy_clk | input | 1 | 1: time outputs by `phy_tick`; 0: by `int_tick` |
| phy_tick | input | 1 | One-cycle strobe per PHY transmit clock edge |
| int_tick | input | 1 | One-cycle strobe per internal 25 MHz clock edge |
| in_data | input | 8 | Frame byte from the core |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | Current byte is the last of the frame |
| in_err_req | input | 1 | Core requests a coding error from this byte on |
| in_collision | input | 1 | Collision indication |
| in_ready | output | 1 | Byte is taken this cycle when `in_valid` is high |
| rx_dv | input | 1 | Receive data valid from the PHY |
| link_ok | output | 1 | Link status, follows `rx_dv` |
| tx_en | output | 1 | MII transmit enable |
| tx_er | output | 1 | MII transmit error |
| txd | output | 4 | MII transmit data (bit 0 only at 10 Mbit/s) |

## Verification
The bench checks the exact symbol on which data starts. A design that miscounts the preamble moves every data nibble or bit by one, and the symbol-by-symbol comparison catches it. It runs frames timed by each strobe, with pulses on the unselected strobe placed between ticks. A framer that follows the wrong strobe skips symbols. It puts an error request on the same tick as a collision, and puts a collision partway through a flagged frame. A framer that gives the error priority, or does not make it sticky, shows `tx_er` on the wrong symbols. It flips `speed_100` during a frame, starves the framer of data mid-frame, and resets it mid-frame. These catch a framer that follows the live speed input, that waits for late data, or that holds stale output state.

// File: rtl/mii_tx_pkg.sv
// Shared types and constants for the MII transmit framer.
// Assumes a 4-bit MII data path.
package mii_tx_pkg;
    localparam int MII_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    localparam logic [MII_W-1:0] NIB_PREAMBLE = 4'h5;
    localparam logic [MII_W-1:0] NIB_SFD_HI   = 4'hD;
endpackage

// File: rtl/mii_tx_seq.sv
// Frame sequencer: walks idle -> preamble -> data, counts preamble symbols
// and the symbols of the current byte, and requests bytes from the core.
// Assumes tick is a single-cycle strobe. The mode is latched at frame start.
module mii_tx_seq
    import mii_tx_pkg::*;
#(
    parameter  int PRE_OCTETS = 7,
    parameter  int BYTE_W     = 8,
    localparam int SYM_FAST   = (BYTE_W / MII_W) * (PRE_OCTETS + 1),
    localparam int SYM_SLOW   = BYTE_W * (PRE_OCTETS + 1),
    localparam int CNT_W      = $clog2(SYM_SLOW),
    localparam int POS_W      = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             speed_100,
    input  logic             in_valid,
    input  logic             in_last,
    output phase_t           phase,
    output logic [CNT_W-1:0] pre_cnt,
    output logic             fast,
    output logic             in_ready,
    output logic             take,
    output logic             start
);
    logic [POS_W-1:0] pos;
    logic             last_q;
    logic [CNT_W-1:0] pre_end;
    logic [POS_W-1:0] pos_end;
    logic             need_byte;

    // Decode the end of the preamble and of a byte, and the handshake.
    always_comb begin
        pre_end   = fast ? CNT_W'(SYM_FAST - 1) : CNT_W'(SYM_SLOW - 1);
        pos_end   = fast ? POS_W'(BYTE_W / MII_W - 1) : POS_W'(BYTE_W - 1);
        need_byte = ((phase == PH_PRE) && (pre_cnt == pre_end)) ||
                    ((phase == PH_DATA) && (pos == pos_end) && !last_q);
        in_ready  = tick && need_byte;
        take      = in_ready && in_valid;
        start     = tick && (phase == PH_IDLE) && in_valid;
    end

    // Advance the frame phase and counters on each selected tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pre_cnt <= '0;
            pos     <= '0;
            last_q  <= 1'b0;
            fast    <= 1'b0;
        end else if (tick) begin
            unique case (phase)
                PH_IDLE: begin
                    if (in_valid) begin
                        phase   <= PH_PRE;
                        pre_cnt <= '0;
                        fast    <= speed_100;
                    end
                end
                PH_PRE: begin
                    if (need_byte) begin
                        if (in_valid) begin
                            phase  <= PH_DATA;
                            pos    <= '0;
                            last_q <= in_last;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        pre_cnt <= pre_cnt + CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    if (pos == pos_end) begin
                        if (last_q || !in_valid) begin
                            phase <= PH_IDLE;
                        end else begin
                            pos    <= '0;
                            last_q <= in_last;
                        end
                    end else begin
                        pos <= pos + POS_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mii_tx_symgen.sv
// Symbol generator: holds the current byte in a shift register and forms
// the MII data symbol for the present phase and speed.
// Assumes BYTE_W is a multiple of the MII width. txd is decoded from state
// that only changes on a tick.
module mii_tx_symgen
    import mii_tx_pkg::*;
#(
    parameter  int PRE_OCTETS = 7,
    parameter  int BYTE_W     = 8,
    localparam int SYM_FAST   = (BYTE_W / MII_W) * (PRE_OCTETS + 1),
    localparam int SYM_SLOW   = BYTE_W * (PRE_OCTETS + 1),
    localparam int CNT_W      = $clog2(SYM_SLOW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              take,
    input  logic              fast,
    input  phase_t            phase,
    input  logic [CNT_W-1:0]  pre_cnt,
    input  logic [BYTE_W-1:0] in_data,
    output logic [MII_W-1:0]  txd
);
    localparam logic [CNT_W-1:0] SFD_IDX  = CNT_W'(SYM_FAST - 1);
    localparam logic [CNT_W-1:0] TAIL_IDX = CNT_W'(SYM_SLOW - 2);

    logic [BYTE_W-1:0] shreg;

    // Load a new byte when it is taken, else shift out one symbol per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (take) begin
            shreg <= in_data;
        end else if (tick && (phase == PH_DATA)) begin
            shreg <= fast ? (shreg >> MII_W) : (shreg >> 1);
        end
    end

    // Select the preamble, delimiter or data symbol for the wire.
    always_comb begin
        txd = '0;
        unique case (phase)
            PH_PRE: begin
                if (fast) begin
                    txd = (pre_cnt == SFD_IDX) ? NIB_SFD_HI : NIB_PREAMBLE;
                end else begin
                    txd[0] = (pre_cnt >= TAIL_IDX) ? 1'b1 : ~pre_cnt[0];
                end
            end
            PH_DATA: begin
                if (fast) begin
                    txd = shreg[MII_W-1:0];
                end else begin
                    txd[0] = shreg[0];
                end
            end
            default: txd = '0;
        endcase
    end
endmodule

// File: rtl/mii_tx_errtrk.sv
// Error tracker: remembers a coding-error request for the rest of a frame,
// and drops it on any collision tick. A collision beats a same-tick request.
// Assumes start, take and collision are only acted on with tick.
module mii_tx_errtrk (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic take,
    input  logic err_req,
    input  logic collision,
    output logic err_q
);
    // Set on a flagged byte, clear on collision or on a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (tick) begin
            if (collision) begin
                err_q <= 1'b0;
            end else if (take && err_req) begin
                err_q <= 1'b1;
            end else if (start) begin
                err_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mii_tx_framer.sv
// Top level of the dual-speed MII transmit framer.
// Picks the timing strobe, and joins the sequencer, symbol generator and
// error tracker. Assumes both strobes are synchronous single-cycle pulses.
module mii_tx_framer
    import mii_tx_pkg::*;
#(
    parameter  int PRE_OCTETS = 7,
    parameter  int BYTE_W     = 8,
    localparam int SYM_SLOW   = BYTE_W * (PRE_OCTETS + 1),
    localparam int CNT_W      = $clog2(SYM_SLOW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_100,
    input  logic              use_phy_clk,
    input  logic              phy_tick,
    input  logic              int_tick,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_err_req,
    input  logic              in_collision,
    output logic              in_ready,
    input  logic              rx_dv,
    output logic              link_ok,
    output logic              tx_en,
    output logic              tx_er,
    output logic [MII_W-1:0]  txd
);
    logic             tick;
    phase_t           phase;
    logic [CNT_W-1:0] pre_cnt;
    logic             frame_fast;
    logic             take;
    logic             start;
    logic             err_q;

    // Choose the strobe that times the outputs.
    assign tick = use_phy_clk ? phy_tick : int_tick;

    mii_tx_seq #(.PRE_OCTETS(PRE_OCTETS), .BYTE_W(BYTE_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .speed_100(speed_100),
        .in_valid (in_valid),
        .in_last  (in_last),
        .phase    (phase),
        .pre_cnt  (pre_cnt),
        .fast     (frame_fast),
        .in_ready (in_ready),
        .take     (take),
        .start    (start)
    );

    mii_tx_symgen #(.PRE_OCTETS(PRE_OCTETS), .BYTE_W(BYTE_W)) i_symgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .take   (take),
        .fast   (frame_fast),
        .phase  (phase),
        .pre_cnt(pre_cnt),
        .in_data(in_data),
        .txd    (txd)
    );

    mii_tx_errtrk i_errtrk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .take     (take),
        .err_req  (in_err_req),
        .collision(in_collision),
        .err_q    (err_q)
    );

    // Drive the frame enable, the error line (100 Mbit/s only) and link status.
    assign tx_en   = (phase != PH_IDLE);
    assign tx_er   = err_q && frame_fast && (phase != PH_IDLE);
    assign link_ok = rx_dv;
endmodule

// File: rtl/mii_tx_framer_checker.sv
// Checker for mii_tx_framer, bound to every instance of it.
// Observes the ports and the latched frame speed.
module mii_tx_framer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       use_phy_clk,
    input logic       phy_tick,
    input logic       int_tick,
    input logic       in_collision,
    input logic       in_ready,
    input logic       rx_dv,
    input logic       link_ok,
    input logic       tx_en,
    input logic       tx_er,
    input logic [3:0] txd,
    input logic       frame_fast
);
    logic sel_tick;
    assign sel_tick = use_phy_clk ? phy_tick : int_tick;

    assert_en_first_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && frame_fast) |-> (txd == 4'h5));

    assert_hold_off_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> $stable({tx_en, tx_er, txd}));

    assert_ready_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> sel_tick);

    assert_er_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |-> tx_en);

    assert_collision_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_tick && in_collision) |=> !tx_er);

    assert_slow_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !frame_fast) |-> (!tx_er && (txd[3:1] == 3'b000)));

    assert_link_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok == rx_dv);
endmodule

bind mii_tx_framer mii_tx_framer_checker i_chk (.*);

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {underrun, fast, use_phy, len, first byte, err byte (3 = none), collision symbol (255 = none)}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 2'd1, 8'hA5, 2'd3, 8'd255},
        {1'b0, 1'b1, 1'b1, 2'd3, 8'h3C, 2'd3, 8'd255},
        {1'b0, 1'b0, 1'b0, 2'd2, 8'h96, 2'd3, 8'd255},
        {1'b0, 1'b1, 1'b0, 2'd3, 8'h5A, 2'd1, 8'd255},
        {1'b0, 1'b1, 1'b0, 2'd3, 8'hC3, 2'd0, 8'd20},
        {1'b0, 1'b1, 1'b0, 2'd2, 8'h0F, 2'd1, 8'd18},
        {1'b0, 1'b0, 1'b1, 2'd1, 8'hE1, 2'd0, 8'd255},
        {1'b1, 1'b1, 1'b0, 2'd1, 8'h81, 2'd3, 8'd255}
    };

    logic       clk, rst_n, speed_100, use_phy_clk, phy_tick, int_tick;
    logic [7:0] in_data;
    logic       in_valid, in_last, in_err_req, in_collision, in_ready;
    logic       rx_dv, link_ok, tx_en, tx_er;
    logic [3:0] txd;
    int         n_checks = 0;
    int         n_fail   = 0;

    mii_tx_framer i_mii_tx_framer (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .use_phy_clk(use_phy_clk),
        .phy_tick(phy_tick), .int_tick(int_tick), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_err_req(in_err_req),
        .in_collision(in_collision), .in_ready(in_ready), .rx_dv(rx_dv),
        .link_ok(link_ok), .tx_en(tx_en), .tx_er(tx_er), .txd(txd)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [7:0] b0, input int k);
        return b0 + 8'(39 * k);
    endfunction

    // Expected wire symbol i of a frame, from the R3 and R4 encodings.
    function automatic logic [3:0] exp_sym(input logic fast, input int i, input logic [7:0] b0);
        logic [7:0] b;
        if (fast) begin
            if (i < 15) return 4'h5;
            if (i == 15) return 4'hD;
            b = byte_of(b0, (i - 16) / 2);
            return (((i - 16) % 2) == 0) ? b[3:0] : b[7:4];
        end
        if (i < 62) return ((i % 2) == 0) ? 4'h1 : 4'h0;
        if (i < 64) return 4'h1;
        b = byte_of(b0, (i - 64) / 8);
        return {3'b000, b[(i - 64) % 8]};
    endfunction

    // One selected tick, then one cycle with a pulse on the unselected strobe.
    task automatic tick_once(output logic rdy);
        @(negedge clk);
        phy_tick = use_phy_clk;
        int_tick = !use_phy_clk;
        #1 rdy = in_ready;
        @(negedge clk);
        phy_tick = !use_phy_clk;
        int_tick = use_phy_clk;
        #1;
    endtask

    task automatic run_frame(input logic [22:0] v);
        logic       under, fast, phy, rdy, exp_er;
        int         len, err, coll, nsym, acc_sym, accepted, k;
        logic [7:0] b0;
        string      dtag, etag;
        under = v[22]; fast = v[21]; phy = v[20]; len = int'(v[19:18]);
        b0 = v[17:10]; err = int'(v[9:8]); coll = int'(v[7:0]);
        @(negedge clk);
        phy_tick = 1'b0; int_tick = 1'b0;
        speed_100 = fast; use_phy_clk = phy;
        k = 0; accepted = 0;
        in_valid = 1'b1; in_data = byte_of(b0, 0);
        in_last = !under && (len == 1); in_err_req = (err == 0);
        nsym    = fast ? 16 + 2 * len : 64 + 8 * len;
        acc_sym = fast ? 16 + 2 * err : 64 + 8 * err;
        dtag = $sformatf("%s R10%s", fast ? "R3" : "R4", phy ? " R2" : "");
        etag = !fast ? "R9" : ((coll != 255) ? "R8" : "R7");
        for (int i = 0; i < nsym; i++) begin
            in_collision = (i == coll);
            tick_once(rdy);
            in_collision = 1'b0;
            if (i == 0) speed_100 = !fast;   // R10: live speed change is ignored
            if (rdy && in_valid) begin
                accepted++;
                k++;
                if (k < len) begin
                    in_data = byte_of(b0, k);
                    in_last = !under && (k == len - 1);
                    in_err_req = (err == k);
                end else begin
                    in_valid = 1'b0; in_last = 1'b0; in_err_req = 1'b0;
                end
            end
            exp_er = fast && (err != 3) && (acc_sym <= i) && !((coll >= acc_sym) && (coll <= i));
            check(dtag, $sformatf("txd sym %0d", i), {4'h0, txd}, {4'h0, exp_sym(fast, i, b0)});
            check(dtag, $sformatf("tx_en sym %0d", i), {7'h0, tx_en}, 8'h1);
            check(etag, $sformatf("tx_er sym %0d", i), {7'h0, tx_er}, {7'h0, exp_er});
        end
        tick_once(rdy);
        check(under ? "R11" : "R5", "tx_en after frame", {7'h0, tx_en}, 8'h0);
        check(under ? "R11" : "R5", "txd after frame", {4'h0, txd}, 8'h0);
        check("R7", "tx_er after frame", {7'h0, tx_er}, 8'h0);
        check("R6", "in_ready on final tick", {7'h0, rdy}, {7'h0, under});
        check("R6", "bytes taken", 8'(accepted), 8'(len));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic rdy;
        rst_n = 1'b0; speed_100 = 1'b0; use_phy_clk = 1'b0; phy_tick = 1'b0;
        int_tick = 1'b0; in_data = 8'h00; in_valid = 1'b0; in_last = 1'b0;
        in_err_req = 1'b0; in_collision = 1'b0; rx_dv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", "tx_en after reset", {7'h0, tx_en}, 8'h0);
        check("R1", "tx_er after reset", {7'h0, tx_er}, 8'h0);
        check("R1", "txd after reset", {4'h0, txd}, 8'h0);
        check("R1", "in_ready after reset", {7'h0, in_ready}, 8'h0);

        rx_dv = 1'b1;
        #1 check("R12", "link_ok high", {7'h0, link_ok}, 8'h1);
        rx_dv = 1'b0;
        #1 check("R12", "link_ok low", {7'h0, link_ok}, 8'h0);

        for (int v = 0; v < NVEC; v++) run_frame(VEC[v]);

        // R1: reset in the middle of a frame
        @(negedge clk);
        phy_tick = 1'b0; int_tick = 1'b0; use_phy_clk = 1'b0; speed_100 = 1'b1;
        in_valid = 1'b1; in_data = 8'h77; in_last = 1'b1; in_err_req = 1'b1;
        repeat (5) tick_once(rdy);
        check("R1", "tx_en mid frame", {7'h0, tx_en}, 8'h1);
        @(negedge clk);
        phy_tick = 1'b0; int_tick = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "tx_en during reset", {7'h0, tx_en}, 8'h0);
        check("R1", "txd during reset", {4'h0, txd}, 8'h0);
        rst_n = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_err_req = 1'b0;
        tick_once(rdy);
        check("R1", "idle after reset", {7'h0, tx_en}, 8'h0);
        check("R1", "in_ready idle", {7'h0, rdy}, 8'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule